// File: doc/BRIEF.md
# Pre-Trigger Circular Port Recorder

The recorder takes a snapshot of a wide input port on every clock cycle and writes it into an on-chip ring buffer. Each snapshot is stored with a cycle stamp, so the edge times of every input line can be worked out after the event, and any gap in the capture shows up as a jump in the stamps. After an arm pulse the recorder waits for a trigger. While it waits, it keeps overwriting the oldest entries, so the history leading up to the trigger is always in the buffer.

The trigger is a rising edge on one selectable port bit. After the trigger, the recorder stores a programmed number of further samples. It stops early if every bit of a programmed stop mask is high in the same sample. It then freezes. In the frozen state the trigger index and the final write pointer are held. A flag tells whether the ring wrapped before the trigger, which fixes how many pre-trigger entries are valid. Readout takes an offset relative to the trigger index. A new arm pulse clears the frozen state and starts a fresh record.

Top module: `port_capture_ring`

## Requirements
- R1: After reset the block is idle. `waiting`, `post_active`, `frozen` and `wrapped` are 0, `wr_ptr` and `trig_idx` are 0, and `rd_data` and `rd_stamp` are 0.
- R2: In every cycle that is in the waiting or post-trigger phase and has no arm pulse, the entry at `wr_ptr` receives {`port_in`, stamp}. The stamp is the number of recorded cycles since the last arm, starting at 0. `wr_ptr` then advances by one modulo DEPTH.
- R3: While waiting, the trigger is a sample whose bit `trig_sel` is 1 when the same bit was 0 in the previous cycle. That sample is stored and its index is latched into `trig_idx`. A bit that stays high from before never triggers.
- R4: After the trigger sample, exactly `post_limit` further samples are stored and the block freezes. A limit of 0 freezes in the trigger cycle. While frozen, `wr_ptr` and the buffer stay unchanged.
- R5: In the post-trigger phase, with `stop_mask` nonzero, a sample in which every masked bit is 1 is stored and the block freezes at once. The trigger sample itself is not tested for the stop condition.
- R6: `wrapped` becomes 1 when a waiting-phase sample that is not the trigger is written at index DEPTH-1. It then stays 1 until the next arm.
- R7: While frozen, `rd_data` and `rd_stamp` show, one cycle later, the entry at index (`trig_idx` + `rd_offset`) mod DEPTH, with `rd_offset` taken as two's complement. When the block is not frozen, both outputs read 0 on the next cycle.
- R8: An arm pulse in any state takes priority over everything else. The block enters the waiting phase with `wr_ptr`, `trig_idx` and the stamp at 0 and `wrapped` clear. `trig_sel`, `stop_mask` and `post_limit` are latched at the arm pulse. No sample is stored in the arm cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_in | input | WIDTH | Port sampled every cycle |
| arm | input | 1 | Start or restart a record |
| trig_sel | input | $clog2(WIDTH) | Bit watched for the rising-edge trigger, latched on arm |
| stop_mask | input | WIDTH | Bits that must all be high to stop early (0 disables), latched on arm |
| post_limit | input | $clog2(DEPTH) | Samples to store after the trigger, latched on arm |
| rd_offset | input | $clog2(DEPTH) | Two's-complement readout offset from the trigger index |
| rd_data | output | WIDTH | Port value of the addressed entry |
| rd_stamp | output | STAMP_W | Cycle stamp of the addressed entry |
| waiting | output | 1 | Armed and waiting for the trigger |
| post_active | output | 1 | Capturing after the trigger |
| frozen | output | 1 | Record complete, buffer held |
| wrapped | output | 1 | Ring wrapped before the trigger |
| trig_idx | output | $clog2(DEPTH) | Buffer index of the trigger sample |
| wr_ptr | output | $clog2(DEPTH) | Next write index (one past the last sample once frozen) |

## Verification
The bench targets five corner cases:
- **Trigger bit already high when armed.** A design that detects level instead of edge would trigger at once and record the wrong trigger index.
- **Post limit of zero, and a trigger that lands after more than a full ring of waiting.** Off-by-one errors in the freeze count or in setting the wrap flag move `wr_ptr`, `trig_idx` or `wrapped` by one.
- **Stop condition.** The stop pattern is present on the trigger sample itself, then appears only partially, then appears in full. A design that tests the trigger sample, or accepts any masked bit, freezes early.
- **Negative readout offsets.** These reach across the ring boundary and expose wrong modular addressing.
- **Re-arm mid-capture and while frozen.** A design that lacks arm priority keeps stale pointers or flags.

// File: rtl/capring_pkg.sv
// Shared types for the circular port recorder.
package capring_pkg;
    // Phases of one record, from arm to freeze.
    typedef enum logic [1:0] {
        CR_IDLE   = 2'd0,
        CR_PRE    = 2'd1,
        CR_POST   = 2'd2,
        CR_FROZEN = 2'd3
    } cr_state_e;
endpackage

// File: rtl/capring_trigger.sv
// Trigger and stop detection.
// Latches the watched bit and the stop mask on arm, and keeps the previous
// port sample so that a rising edge is recognised. Assumes WIDTH is a power of two.
module capring_trigger #(
    parameter int WIDTH = 32,
    localparam int SEL_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [SEL_W-1:0] trig_sel,
    input  logic [WIDTH-1:0] stop_mask,
    input  logic [WIDTH-1:0] port_in,
    output logic             trig_hit,
    output logic             stop_hit
);
    logic [SEL_W-1:0] sel_q;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] prev_q;

    // Latch the configuration on arm; keep last cycle's port value every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            mask_q <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= port_in;
            if (arm) begin
                sel_q  <= trig_sel;
                mask_q <= stop_mask;
            end
        end
    end

    // Rising edge on the watched bit, and all masked bits high with a nonzero mask.
    always_comb begin
        trig_hit = port_in[sel_q] & ~prev_q[sel_q];
        stop_hit = (mask_q != '0) && ((port_in & mask_q) == mask_q);
    end
endmodule

// File: rtl/capring_ctrl.sv
// Record controller.
// Runs the arm / wait / post / freeze sequence and keeps the write pointer,
// the cycle stamp, the post-trigger count, the trigger index and the wrap flag.
// Assumes DEPTH is a power of two, so the pointer wraps on its own.
module capring_ctrl
    import capring_pkg::*;
#(
    parameter int DEPTH   = 1024,
    parameter int STAMP_W = 16,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic [AW-1:0]      post_limit,
    input  logic               trig_hit,
    input  logic               stop_hit,
    output cr_state_e          state,
    output logic               wr_en,
    output logic [AW-1:0]      wr_ptr,
    output logic [STAMP_W-1:0] stamp,
    output logic [AW-1:0]      trig_idx,
    output logic               wrapped
);
    logic [AW-1:0] post_cnt;
    logic [AW-1:0] limit_q;

    // A sample is stored in every waiting or post cycle that carries no arm pulse.
    always_comb begin
        wr_en = !arm && ((state == CR_PRE) || (state == CR_POST));
    end

    // Phase sequencing and record bookkeeping; arm has priority over everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CR_IDLE;
            wr_ptr   <= '0;
            stamp    <= '0;
            trig_idx <= '0;
            wrapped  <= 1'b0;
            post_cnt <= '0;
            limit_q  <= '0;
        end else if (arm) begin
            state    <= CR_PRE;
            wr_ptr   <= '0;
            stamp    <= '0;
            trig_idx <= '0;
            wrapped  <= 1'b0;
            post_cnt <= '0;
            limit_q  <= post_limit;
        end else begin
            case (state)
                CR_PRE: begin
                    wr_ptr <= wr_ptr + 1'b1;
                    stamp  <= stamp + 1'b1;
                    if (trig_hit) begin
                        trig_idx <= wr_ptr;
                        post_cnt <= '0;
                        state    <= (limit_q == '0) ? CR_FROZEN : CR_POST;
                    end else if (wr_ptr == AW'(DEPTH - 1)) begin
                        wrapped <= 1'b1;
                    end
                end
                CR_POST: begin
                    wr_ptr   <= wr_ptr + 1'b1;
                    stamp    <= stamp + 1'b1;
                    post_cnt <= post_cnt + 1'b1;
                    if ((post_cnt + 1'b1 == limit_q) || stop_hit) begin
                        state <= CR_FROZEN;
                    end
                end
                default: begin
                    state <= state;
                end
            endcase
        end
    end
endmodule

// File: rtl/capring_mem.sv
// Sample storage.
// One write port and one registered read port. The read output is cleared
// when reading is not enabled. Contents are not reset.
module capring_mem #(
    parameter int DEPTH = 1024,
    parameter int DW    = 48,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_q
);
    logic [DW-1:0] store [DEPTH];

    // Store one sample per enabled cycle.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    // Registered readout, zero when not enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= store[rd_addr];
        end else begin
            rd_q <= '0;
        end
    end
endmodule

// File: rtl/port_capture_ring.sv
// Pre-trigger circular port recorder, top level.
// Samples port_in every cycle into a ring with a cycle stamp, triggers on a
// rising edge of a selected bit, stores a bounded post-trigger window and
// freezes for readout relative to the trigger index.
// Assumes WIDTH and DEPTH are powers of two.
module port_capture_ring
    import capring_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int DEPTH   = 1024,
    parameter int STAMP_W = 16,
    localparam int AW     = $clog2(DEPTH),
    localparam int SEL_W  = $clog2(WIDTH),
    localparam int DW     = WIDTH + STAMP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH-1:0]   port_in,
    input  logic               arm,
    input  logic [SEL_W-1:0]   trig_sel,
    input  logic [WIDTH-1:0]   stop_mask,
    input  logic [AW-1:0]      post_limit,
    input  logic [AW-1:0]      rd_offset,
    output logic [WIDTH-1:0]   rd_data,
    output logic [STAMP_W-1:0] rd_stamp,
    output logic               waiting,
    output logic               post_active,
    output logic               frozen,
    output logic               wrapped,
    output logic [AW-1:0]      trig_idx,
    output logic [AW-1:0]      wr_ptr
);
    cr_state_e          state;
    logic               trig_hit;
    logic               stop_hit;
    logic               wr_en;
    logic [STAMP_W-1:0] stamp;
    logic [DW-1:0]      rd_q;
    logic [AW-1:0]      rd_addr;

    capring_trigger #(.WIDTH(WIDTH)) trig_u (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trig_sel(trig_sel),
        .stop_mask(stop_mask), .port_in(port_in),
        .trig_hit(trig_hit), .stop_hit(stop_hit)
    );

    capring_ctrl #(.DEPTH(DEPTH), .STAMP_W(STAMP_W)) ctrl_u (
        .clk(clk), .rst_n(rst_n), .arm(arm), .post_limit(post_limit),
        .trig_hit(trig_hit), .stop_hit(stop_hit), .state(state),
        .wr_en(wr_en), .wr_ptr(wr_ptr), .stamp(stamp),
        .trig_idx(trig_idx), .wrapped(wrapped)
    );

    // Readout address is relative to the trigger and wraps around the ring.
    always_comb begin
        rd_addr = trig_idx + rd_offset;
    end

    capring_mem #(.DEPTH(DEPTH), .DW(DW)) mem_u (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_ptr),
        .wr_data({port_in, stamp}), .rd_en(state == CR_FROZEN),
        .rd_addr(rd_addr), .rd_q(rd_q)
    );

    // Split the stored word and decode the phase flags.
    always_comb begin
        rd_data     = rd_q[DW-1:STAMP_W];
        rd_stamp    = rd_q[STAMP_W-1:0];
        waiting     = (state == CR_PRE);
        post_active = (state == CR_POST);
        frozen      = (state == CR_FROZEN);
    end
endmodule

// File: rtl/capring_chk.sv
// Temporal checks on the recorder's ports, attached to the top by bind.
module capring_chk #(
    parameter int WIDTH = 32,
    parameter int AW    = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             waiting,
    input logic             post_active,
    input logic             frozen,
    input logic             wrapped,
    input logic [AW-1:0]    wr_ptr,
    input logic [AW-1:0]    trig_idx,
    input logic [WIDTH-1:0] rd_data
);
    // R1
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({waiting, post_active, frozen}));

    // R2
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting || post_active) && !arm |=> wr_ptr == AW'($past(wr_ptr) + 1'b1));

    // R3
    trig_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post_active || frozen) && $past(waiting) && !$past(arm) |-> trig_idx == $past(wr_ptr));

    // R4
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen && !arm |=> frozen && $stable(wr_ptr) && $stable(trig_idx));

    // R6
    wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrapped && !arm |=> wrapped);

    // R7
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frozen) |-> rd_data == '0);

    // R8
    arm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> waiting && wr_ptr == '0 && trig_idx == '0 && !wrapped);
endmodule

bind port_capture_ring capring_chk #(.WIDTH(WIDTH), .AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .waiting(waiting),
    .post_active(post_active), .frozen(frozen), .wrapped(wrapped),
    .wr_ptr(wr_ptr), .trig_idx(trig_idx), .rd_data(rd_data)
);

// File: tb/port_capture_ring_tb_top.sv
// Bench: behavioural reference model compared with the recorder on every clock.
module port_capture_ring_tb_top;
    localparam int WIDTH = 32;
    localparam int DEPTH = 1024;
    localparam int STAMP_W = 16;
    localparam int AW = $clog2(DEPTH);
    localparam int SEL_W = $clog2(WIDTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [WIDTH-1:0] pi = '0;
    logic armi = 1'b0;
    logic [SEL_W-1:0] seli = '0;
    logic [WIDTH-1:0] maski = '0;
    logic [AW-1:0] limi = '0;
    logic [AW-1:0] offi = '0;
    logic [WIDTH-1:0] rd_data;
    logic [STAMP_W-1:0] rd_stamp;
    logic waiting, post_active, frozen, wrapped;
    logic [AW-1:0] trig_idx, wr_ptr;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    // Reference model state
    int ms = 0;
    int mwr = 0, mstamp = 0, mpc = 0, mlim = 0, mtrig = 0, msel = 0;
    bit mwrap = 0;
    logic [WIDTH-1:0] mmask = '0, mprev = '0;
    logic [WIDTH-1:0] mdat [DEPTH];
    int mstp [DEPTH];
    bit mval [DEPTH];
    logic [WIDTH-1:0] erd = '0;
    int erst = 0;
    bit erv = 1;

    always #10 clk = ~clk;

    port_capture_ring #(.WIDTH(WIDTH), .DEPTH(DEPTH), .STAMP_W(STAMP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .port_in(pi), .arm(armi), .trig_sel(seli),
        .stop_mask(maski), .post_limit(limi), .rd_offset(offi),
        .rd_data(rd_data), .rd_stamp(rd_stamp), .waiting(waiting),
        .post_active(post_active), .frozen(frozen), .wrapped(wrapped),
        .trig_idx(trig_idx), .wr_ptr(wr_ptr)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model one clock edge with the inputs currently applied.
    task automatic model_edge();
        bit th, sh;
        int ra;
        ra = (mtrig + int'(offi)) % DEPTH;
        erv = (ms != 3) || mval[ra];
        erd = (ms == 3) ? mdat[ra] : '0;
        erst = (ms == 3) ? mstp[ra] : 0;
        if (!rst_n) begin
            ms = 0; mwr = 0; mstamp = 0; mpc = 0; mlim = 0; mtrig = 0;
            msel = 0; mwrap = 0; mmask = '0; mprev = '0;
            erd = '0; erst = 0; erv = 1;
            return;
        end
        th = pi[msel] && !mprev[msel];
        sh = (mmask != '0) && ((pi & mmask) == mmask);
        if (armi) begin
            ms = 1; mwr = 0; mstamp = 0; mpc = 0; mtrig = 0; mwrap = 0;
            msel = int'(seli); mmask = maski; mlim = int'(limi);
        end else if (ms == 1 || ms == 2) begin
            mdat[mwr] = pi;
            mstp[mwr] = mstamp % (1 << STAMP_W);
            mval[mwr] = 1;
            if (ms == 1) begin
                if (th) begin
                    mtrig = mwr; mpc = 0;
                    ms = (mlim == 0) ? 3 : 2;
                end else if (mwr == DEPTH - 1) begin
                    mwrap = 1;
                end
            end else begin
                mpc++;
                if (mpc == mlim || sh) ms = 3;
            end
            mwr = (mwr + 1) % DEPTH;
            mstamp++;
        end
        mprev = pi;
    endtask

    task automatic compare_all();
        chk("R4 waiting flag", waiting, ms == 1);
        chk("R4 post flag", post_active, ms == 2);
        chk("R4 frozen flag", frozen, ms == 3);
        chk("R2 write pointer", wr_ptr, mwr);
        chk("R3 trigger index", trig_idx, mtrig);
        chk("R6 wrap flag", wrapped, mwrap);
        if (erv) begin
            chk("R7 readout data", rd_data, erd);
            chk("R7 readout stamp", rd_stamp, erst);
        end
    endtask

    // One clock: model at the edge, compare at the falling edge.
    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic arm_it(input int sel, input logic [WIDTH-1:0] mask, input int lim);
        seli = SEL_W'(sel); maski = mask; limi = AW'(lim); armi = 1'b1;
        cyc();
        armi = 1'b0;
        chk("R8 arm enters waiting", {waiting, frozen, wrapped}, 3'b100);
        chk("R8 arm clears pointer", wr_ptr, 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mval[i] = 0; mdat[i] = '0; mstp[i] = 0;
        end
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc();
        rst_n = 1'b1;
        chk("R1 reset flags", {waiting, post_active, frozen, wrapped}, 4'b0000);
        chk("R1 reset pointers", {wr_ptr, trig_idx}, '0);
        chk("R1 reset readout", {rd_data, rd_stamp}, '0);

        // Scenario A: edge trigger, post limit of five
        arm_it(3, '0, 5);
        for (int i = 0; i < 10; i++) begin pi = $urandom() & ~32'h8; cyc(); end
        pi = $urandom() | 32'h8; cyc();
        chk("R3 trigger seen", post_active, 1);
        for (int i = 0; i < 5; i++) begin pi = $urandom(); cyc(); end
        chk("R4 frozen after limit", frozen, 1);
        chk("R3 trigger at ten", trig_idx, 10);
        chk("R4 final pointer", wr_ptr, 16);
        for (int i = 0; i < 3; i++) begin pi = $urandom(); cyc(); end
        chk("R4 pointer held", wr_ptr, 16);
        for (int k = -10; k <= 5; k++) begin offi = AW'(k); cyc(); end
        offi = '0; cyc(); cyc();
        chk("R7 trigger sample bit", rd_data[3], 1);
        chk("R2 trigger stamp", rd_stamp, 10);

        // Scenario B: stop mask, present on trigger sample, partial, then full
        arm_it(0, 32'h00F0_0000, 200);
        for (int i = 0; i < 4; i++) begin pi = 32'h0; cyc(); end
        pi = 32'h00F0_0001; cyc();
        chk("R5 trigger sample not a stop", post_active, 1);
        for (int i = 0; i < 3; i++) begin pi = 32'h0070_0000; cyc(); end
        chk("R5 partial mask no stop", post_active, 1);
        pi = 32'h00F0_0000; cyc();
        chk("R5 full mask stops", frozen, 1);
        chk("R5 stop pointer", wr_ptr, 9);
        offi = AW'(4); cyc(); cyc();
        chk("R5 stop sample stored", rd_data, 32'h00F0_0000);
        offi = '0;

        // Scenario C: bit high across arm gives no trigger; re-arm mid-capture
        pi = 32'h20; cyc();
        arm_it(5, '0, 2);
        for (int i = 0; i < 20; i++) cyc();
        chk("R3 held level no trigger", waiting, 1);
        pi = 32'h0; cyc();
        pi = 32'h20; cyc();
        chk("R3 edge after drop", post_active, 1);
        arm_it(5, '0, 2);
        chk("R8 re-arm mid capture", post_active, 0);

        // Scenario D: wrap before trigger, post limit zero
        arm_it(7, '0, 0);
        pi = '0;
        for (int i = 0; i < 1100; i++) begin pi = $urandom() & ~32'h80; cyc(); end
        chk("R6 wrapped set", wrapped, 1);
        pi = 32'h80; cyc();
        chk("R4 limit zero freezes at trigger", frozen, 1);
        chk("R3 trigger after wrap", trig_idx, 1100 % DEPTH);
        chk("R4 pointer after zero limit", wr_ptr, (1100 % DEPTH) + 1);
        for (int k = -100; k <= 0; k += 7) begin offi = AW'(k); cyc(); end
        offi = '0;

        // Scenario E: re-arm from frozen clears everything
        arm_it(1, '0, 3);
        cyc();
        chk("R7 readout zero when not frozen", rd_data, 0);
        chk("R8 wrap cleared", wrapped, 0);
        for (int i = 0; i < 4; i++) cyc();

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule